// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block fills one cache line after a read miss. A miss request carries the byte address of the word the processor wants. The controller accepts it, issues one wrapping burst request whose start address is that word, and then takes eight 32-bit beats from the memory side. The first beat is the word that missed. It goes straight back to the processor on the return port, one cycle after it arrives, so the core can resume before the rest of the line has landed.

Each beat, the first one included, is also written into the line data array at its own word index. The indices run from the missed index upward and wrap modulo eight. When the eighth word is written the controller raises a one-cycle strobe that marks the line valid, and in the same cycle it clears both half-line dirty bits. While a fill is in progress the controller refuses new miss requests. Choosing the set, comparing tags, picking a victim and writing back dirty data are handled elsewhere.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset `missReady` is 1 and `burstReq`, `wrEn`, `cpuValid`, `validSet` and `dirtyClr` are all 0.
- R2: A miss is accepted on a clock edge where `missValid` and `missReady` are both 1. `missReady` is 0 from the cycle after acceptance up to the cycle in which the eighth word is written, and it is 1 again in that cycle.
- R3: In the cycle after acceptance, `burstReq` is 1 for exactly one cycle and `burstAddr` equals `missAddr` with bits [1:0] cleared.
- R4: The first beat of a fill comes back on `cpuData` with `cpuValid` high for one cycle, in the cycle after that beat's edge. `cpuData` then holds that value until the next fill's first beat.
- R5: Beat n (n = 0..7) of a fill is written at word index (c + n) mod 8, where c = `missAddr[4:2]` of the accepted miss. This holds for every starting index 0 through 7.
- R6: Each accepted beat produces exactly one `wrEn` pulse in the cycle after its edge, with `wrData` equal to that beat's data.
- R7: `validSet` is 1 only in the cycle of the eighth write of a fill and never with an earlier write.
- R8: `dirtyClr` is 2'b11 in the cycle `validSet` is 1, and 2'b00 in every other cycle.
- R9: A `beatValid` while no fill is in progress is ignored: it produces no `wrEn` and no `cpuValid`.
- R10: A `missValid` during a fill is ignored: no second `burstReq` is issued and the write indices of the running fill are unchanged.
- R11: Cycles with `beatValid` low during a fill produce no write and do not advance the beat count. The fill still completes after exactly eight beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A read miss is presented |
| missAddr | input | 32 | Byte address of the missed word |
| missReady | output | 1 | Controller is idle and can take a miss |
| burstReq | output | 1 | One-cycle start of a wrapping 8-beat read burst |
| burstAddr | output | 32 | Word-aligned start address of the burst |
| beatValid | input | 1 | A burst data beat is present |
| beatData | input | 32 | Burst beat data |
| cpuValid | output | 1 | Critical word is returned this cycle |
| cpuData | output | 32 | Critical word returned to the processor |
| wrEn | output | 1 | Write one word into the line data array |
| wrIdx | output | 3 | Word index within the line for the write |
| wrData | output | 32 | Word to write |
| validSet | output | 1 | Mark the line valid (last word written) |
| dirtyClr | output | 2 | Clear the half-line dirty bits |

## Verification
The bench runs fills that start at each of the eight word positions, including index 7, where the sequence wraps straight to 0. A controller that always starts at word zero, or that stops instead of wrapping, writes the wrong index on the first or second beat. Fills with idle gaps between beats catch a counter that advances on empty cycles, which would raise `validSet` one word early and leave a word unwritten. Beats sent while idle, and miss requests repeated during a fill, catch a design that writes stray data or restarts the burst halfway through a line.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fillState_t;

  // strobes from the control to the datapath, valid for the current edge
  typedef struct packed {
    logic capture;   // miss accepted this edge
    logic beatTake;  // beat accepted this edge
    logic first;     // accepted beat is the critical word
    logic last;      // accepted beat completes the line
  } fillStrobe_t;

endpackage

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
  import cwf_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     missValid,
  input  logic                     beatValid,
  output logic                     missReady,
  output fillStrobe_t              strb,
  output logic [$clog2(WORDS)-1:0] beatNum
);

  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST_NUM = IDX_W'(WORDS - 1);

  fillState_t stateQ;
  logic [IDX_W-1:0] cntQ;

  always_comb begin
    strb          = '0;
    strb.capture  = (stateQ == ST_IDLE) && missValid;
    strb.beatTake = (stateQ == ST_FILL) && beatValid;
    strb.first    = strb.beatTake && (cntQ == '0);
    strb.last     = strb.beatTake && (cntQ == LAST_NUM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      if (strb.capture) begin
        stateQ <= ST_FILL;
        cntQ   <= '0;
      end else if (strb.last) begin
        stateQ <= ST_IDLE;
        cntQ   <= '0;
      end else if (strb.beatTake) begin
        cntQ <= cntQ + IDX_W'(1);
      end
    end
  end

  assign missReady = (stateQ == ST_IDLE);
  assign beatNum   = cntQ;

endmodule

// File: rtl/cwf_fill_dpath.sv
module cwf_fill_dpath
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORDS      = 8,
  parameter int DIRTY_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fillStrobe_t              strb,
  input  logic [$clog2(WORDS)-1:0] beatNum,
  input  logic [ADDR_W-1:0]        missAddr,
  input  logic [DATA_W-1:0]        beatData,
  output logic                     burstReq,
  output logic [ADDR_W-1:0]        burstAddr,
  output logic                     cpuValid,
  output logic [DATA_W-1:0]        cpuData,
  output logic                     wrEn,
  output logic [$clog2(WORDS)-1:0] wrIdx,
  output logic [DATA_W-1:0]        wrData,
  output logic                     validSet,
  output logic [DIRTY_BITS-1:0]    dirtyClr
);

  localparam int IDX_W    = $clog2(WORDS);
  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << BYTE_OFF) - 1);

  logic [IDX_W-1:0] critIdxQ;
  logic [IDX_W-1:0] beatIdx;
  logic [ADDR_W-1:0] alignedAddr;

  assign alignedAddr = missAddr & ~OFF_MASK;
  // wrapping index: power-of-two line, so the add simply rolls over
  assign beatIdx = critIdxQ + beatNum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      critIdxQ  <= '0;
      burstReq  <= 1'b0;
      burstAddr <= '0;
    end else begin
      burstReq <= strb.capture;
      if (strb.capture) begin
        critIdxQ  <= alignedAddr[BYTE_OFF +: IDX_W];
        burstAddr <= alignedAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn     <= 1'b0;
      wrIdx    <= '0;
      wrData   <= '0;
      cpuValid <= 1'b0;
      cpuData  <= '0;
      validSet <= 1'b0;
      dirtyClr <= '0;
    end else begin
      wrEn     <= strb.beatTake;
      cpuValid <= strb.first;
      validSet <= strb.last;
      dirtyClr <= strb.last ? '1 : '0;
      if (strb.beatTake) begin
        wrIdx  <= beatIdx;
        wrData <= beatData;
      end
      if (strb.first) cpuData <= beatData;
    end
  end

endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORDS      = 8,
  parameter int DIRTY_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     missValid,
  input  logic [ADDR_W-1:0]        missAddr,
  output logic                     missReady,
  output logic                     burstReq,
  output logic [ADDR_W-1:0]        burstAddr,
  input  logic                     beatValid,
  input  logic [DATA_W-1:0]        beatData,
  output logic                     cpuValid,
  output logic [DATA_W-1:0]        cpuData,
  output logic                     wrEn,
  output logic [$clog2(WORDS)-1:0] wrIdx,
  output logic [DATA_W-1:0]        wrData,
  output logic                     validSet,
  output logic [DIRTY_BITS-1:0]    dirtyClr
);

  localparam int IDX_W = $clog2(WORDS);

  fillStrobe_t      strb;
  logic [IDX_W-1:0] beatNum;

  cwf_fill_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .missValid (missValid),
    .beatValid (beatValid),
    .missReady (missReady),
    .strb      (strb),
    .beatNum   (beatNum)
  );

  cwf_fill_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WORDS      (WORDS),
    .DIRTY_BITS (DIRTY_BITS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .beatNum   (beatNum),
    .missAddr  (missAddr),
    .beatData  (beatData),
    .burstReq  (burstReq),
    .burstAddr (burstAddr),
    .cpuValid  (cpuValid),
    .cpuData   (cpuData),
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .validSet  (validSet),
    .dirtyClr  (dirtyClr)
  );

endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter int WORDS      = 8,
  parameter int DIRTY_BITS = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     missValid,
  input logic                     missReady,
  input logic                     burstReq,
  input logic                     beatValid,
  input logic                     cpuValid,
  input logic                     wrEn,
  input logic [$clog2(WORDS)-1:0] wrIdx,
  input logic                     validSet,
  input logic [DIRTY_BITS-1:0]    dirtyClr
);

  localparam int IDX_W = $clog2(WORDS);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    missValid && missReady |=> !missReady); // R2

  AST_ACCEPT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    missValid && missReady |=> burstReq); // R3

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    burstReq |=> !burstReq); // R3

  AST_CPU_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> wrEn); // R4

  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && $past(wrEn) && !cpuValid |-> wrIdx == IDX_W'($past(wrIdx) + IDX_W'(1))); // R5

  AST_BEAT_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !missReady |=> wrEn); // R6

  AST_VALID_DONE: assert property (@(posedge clk) disable iff (!rstN)
    validSet |-> wrEn && missReady); // R7

  AST_DIRTY_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (dirtyClr != '0) |-> validSet && (dirtyClr == '1)); // R8

  AST_IDLE_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && missReady && !missValid |=> !wrEn && !cpuValid); // R9

  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !missReady && !validSet |=> !burstReq); // R10

endmodule

bind cwf_line_fill cwf_line_fill_chk #(
  .WORDS      (WORDS),
  .DIRTY_BITS (DIRTY_BITS)
) u_chk (.*);

// File: tb/tb_cwf_line_fill.sv
`timescale 1ns/1ps
module tb_cwf_line_fill;

  logic        clk = 1'b0;
  logic        rstN;
  logic        missValid;
  logic [31:0] missAddr;
  logic        missReady;
  logic        burstReq;
  logic [31:0] burstAddr;
  logic        beatValid;
  logic [31:0] beatData;
  logic        cpuValid;
  logic [31:0] cpuData;
  logic        wrEn;
  logic [2:0]  wrIdx;
  logic [31:0] wrData;
  logic        validSet;
  logic [1:0]  dirtyClr;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cwf_line_fill dut (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missAddr(missAddr), .missReady(missReady),
    .burstReq(burstReq), .burstAddr(burstAddr),
    .beatValid(beatValid), .beatData(beatData),
    .cpuValid(cpuValid), .cpuData(cpuData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .validSet(validSet), .dirtyClr(dirtyClr)
  );

  // stimulus table: miss address and a mask of idle cycles before each beat
  localparam int NVEC = 9;
  localparam logic [31:0] VEC_ADDR [NVEC] = '{
    32'h0000_1000, 32'h0000_2024, 32'h0001_0048, 32'h8000_006F,
    32'hFFFF_FF90, 32'h1234_5675, 32'h0000_0018, 32'h0ABC_DE1E,
    32'h0000_001C
  };
  localparam logic [7:0] VEC_GAPS [NVEC] = '{
    8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h00, 8'h7E, 8'h00, 8'hFF
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] beatVal(input logic [31:0] seed, input int n);
    return seed ^ (32'h0101_0101 * (n + 1)) ^ 32'hC0DE_0000;
  endfunction

  // one complete fill; called at a negedge with all inputs idle
  task automatic doFill(input logic [31:0] addr, input logic [7:0] gaps, input bit midMiss);
    logic [2:0] crit;
    crit = addr[4:2];
    missValid = 1'b1;
    missAddr  = addr;
    chk("R2 ready before accept", {31'b0, missReady}, 32'd1);
    @(negedge clk);
    missValid = 1'b0;
    chk("R3 burstReq", {31'b0, burstReq}, 32'd1);
    chk("R3 burstAddr", burstAddr, addr & 32'hFFFF_FFFC);
    chk("R2 busy after accept", {31'b0, missReady}, 32'd0);
    for (int n = 0; n < 8; n++) begin
      if (gaps[n]) begin
        beatValid = 1'b0;
        missValid = midMiss;
        missAddr  = ~addr;
        @(negedge clk);
        chk("R11 no write on gap", {31'b0, wrEn}, 32'd0);
        chk("R10 no second burst", {31'b0, burstReq}, 32'd0);
      end
      beatValid = 1'b1;
      beatData  = beatVal(addr, n);
      missValid = midMiss;
      missAddr  = ~addr;
      @(negedge clk);
      beatValid = 1'b0;
      missValid = 1'b0;
      chk("R6 wrEn", {31'b0, wrEn}, 32'd1);
      chk("R5 wrIdx wraps", {29'b0, wrIdx}, {29'b0, 3'(crit + 3'(n))});
      chk("R6 wrData", wrData, beatVal(addr, n));
      chk("R4 cpuValid once", {31'b0, cpuValid}, {31'b0, n == 0});
      if (n == 0) chk("R4 cpuData critical", cpuData, beatVal(addr, 0));
      chk("R7 validSet on last only", {31'b0, validSet}, {31'b0, n == 7});
      chk("R8 dirtyClr", {30'b0, dirtyClr}, (n == 7) ? 32'd3 : 32'd0);
      chk("R2 ready returns at last write", {31'b0, missReady}, {31'b0, n == 7});
      if (n > 0) chk("R10 no second burst", {31'b0, burstReq}, 32'd0);
    end
    @(negedge clk);
    chk("R6 no write after fill", {31'b0, wrEn}, 32'd0);
    chk("R7 validSet pulse ends", {31'b0, validSet}, 32'd0);
    chk("R8 dirtyClr pulse ends", {30'b0, dirtyClr}, 32'd0);
    chk("R4 cpuData holds", cpuData, beatVal(addr, 0));
  endtask

  initial begin
    rstN = 1'b0; missValid = 1'b0; missAddr = '0; beatValid = 1'b0; beatData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 missReady", {31'b0, missReady}, 32'd1);
    chk("R1 burstReq", {31'b0, burstReq}, 32'd0);
    chk("R1 wrEn", {31'b0, wrEn}, 32'd0);
    chk("R1 cpuValid", {31'b0, cpuValid}, 32'd0);
    chk("R1 validSet", {31'b0, validSet}, 32'd0);
    chk("R1 dirtyClr", {30'b0, dirtyClr}, 32'd0);

    // table of fills, every start index, gapped and ungapped
    for (int v = 0; v < NVEC; v++) doFill(VEC_ADDR[v], VEC_GAPS[v], 1'b0);

    // R9: beats while idle are ignored
    for (int k = 0; k < 3; k++) begin
      beatValid = 1'b1;
      beatData  = 32'hDEAD_0000 + 32'(k);
      @(negedge clk);
      chk("R9 idle beat no write", {31'b0, wrEn}, 32'd0);
      chk("R9 idle beat no return", {31'b0, cpuValid}, 32'd0);
      chk("R9 still ready", {31'b0, missReady}, 32'd1);
    end
    beatValid = 1'b0;
    @(negedge clk);
    chk("R9 no late write", {31'b0, wrEn}, 32'd0);

    // R10: misses held high during a fill, with gaps to widen the window
    doFill(32'h0000_0014, 8'h55, 1'b1);
    // R10: back-to-back fill after a busy one, start at index 7
    doFill(32'h0000_007C, 8'h00, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule